// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the engine of a single DMA channel. A 12-bit control word sets how the channel behaves: the transfer size, the stepping mode of each address, whether each side is an I/O device, the port size of the device, which bus-request line to use, and whether the engine gives the bus back when the processor asks for it. Software loads the control word while the channel is idle. It then supplies a source address, a destination address and a byte count, and pulses `start`.

Once started, the engine raises a bus request and waits for a grant. It then alternates read cycles at the source address with write cycles at the destination address. Each cycle waits for `cyc_ack`. After each completed cycle, the address of that side steps by the transfer size. The byte count shrinks on each completed write. When the count is used up, the engine drops its request and raises `done`.

When the general request line is in use and release is enabled, a release request seen as a cycle completes makes the engine drop its request for one cycle. It then requests the bus again and carries on from where it stopped. Data movement is not part of this block.

Top module: `dma_seq_top`

## Requirements
- R1: After synchronous reset, every control field is zero and the block is idle, with `sreq`, `greq`, `rd_stb`, `wr_stb`, `done` and `cfg_err` all low and `bus_addr` and `bus_size` zero.
- R2: Control bits [1:0] set the transfer size: 11 is 1 byte, 10 is 2 bytes, 00 and 01 are 4 bytes. `bus_size` shows this byte count while a strobe is high and is 0 otherwise.
- R3: Control bits [5:4] (source) and [7:6] (destination) set the address stepping. 00 adds the transfer size, 01 subtracts it, and 1x holds the address. The step is applied after each acknowledged cycle on that side, modulo 2^AW.
- R4: After an accepted start, the request is raised in the next cycle. After a grant, the engine drives `rd_stb` with the source address, then `wr_stb` with the destination address, and repeats. A strobe stays high until the cycle in which `cyc_ack` is high, and the two strobes are never high together.
- R5: Each acknowledged write lowers the count by the transfer size. If the count is no larger than the size, the count becomes zero instead. At zero, the request drops, the engine goes idle and `done` rises. `done` stays high until the next accepted start.
- R6: Control bit 10 selects the request line: 1 drives `sreq`, 0 drives `greq`. The request is high from the cycle after an accepted start until the transfer ends or a release occurs.
- R7: With bit 10 = 0 and bit 11 = 1, `rel_req` high in an acknowledged cycle makes both request lines low for the next cycle. The request rises again in the cycle after that. After a new grant, the engine resumes with the pending phase and the saved addresses and count.
- R8: `rel_req` has no effect when bit 10 = 1 or bit 11 = 0.
- R9: Bits 8 (source) and 9 (destination) mark a side as I/O when set. Bits [3:2] give the device port size, with the same encoding as R2. Suppose a start arrives while either side is I/O and the port size differs from the transfer size. Then the start is refused, `cfg_err` rises and the engine stays idle. The port size is ignored when both sides are memory. An accepted start clears `cfg_err`.
- R10: `cfg_wr` loads the control word only while idle. Writes made during a transfer are discarded, and the running and later transfers use the earlier word.
- R11: An accepted start with a zero count raises `done` without requesting the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 12 | Control word value |
| start | input | 1 | Start strobe; captures addresses and count |
| src_start | input | AW | Initial source address |
| dst_start | input | AW | Initial destination address |
| len_start | input | CW | Byte count |
| gnt | input | 1 | Bus grant |
| rel_req | input | 1 | Processor bus-release request |
| cyc_ack | input | 1 | Current bus cycle completes |
| bus_addr | output | AW | Address of the current cycle |
| bus_size | output | 3 | Bytes in the current cycle |
| rd_stb | output | 1 | Read cycle active |
| wr_stb | output | 1 | Write cycle active |
| sreq | output | 1 | Snoop bus request |
| greq | output | 1 | General bus request |
| done | output | 1 | Transfer finished |
| cfg_err | output | 1 | Start refused for port-size mismatch |

## Verification
Every result is registered once. A start, grant, acknowledge or release sampled at one rising edge shows up on the outputs just after that edge, so the request appears one cycle after `start`. A strobe ends in the cycle after its acknowledge, and the release gap lasts exactly one cycle. The bench drives inputs at the falling edge and advances its behavioural model by that same single edge. It compares every output at the next falling edge, so each result is checked in the first cycle in which it is due. The grant and acknowledge delays come from a shift-register pattern, so each job sees varied wait lengths.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef struct packed {
        logic       rel_en;
        logic       use_snoop;
        logic       dst_io;
        logic       src_io;
        logic [1:0] dst_step;
        logic [1:0] src_step;
        logic [1:0] port_sz;
        logic [1:0] xfer_sz;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_REL  = 3'd4
    } seq_state_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b11:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic port_mismatch(input chan_ctrl_t c);
        return (c.src_io || c.dst_io) &&
               (size_bytes(c.port_sz) != size_bytes(c.xfer_sz));
    endfunction

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic [2:0]    bytes,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] delta;

    assign delta  = AW'(bytes);
    assign addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step && !mode[1]) begin
            addr_q <= mode[0] ? addr_q - delta : addr_q + delta;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && mode[1]) |=> (addr_o == $past(addr_o)));

    p_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && mode == 2'b00) |=> (addr_o == $past(addr_o) + AW'($past(bytes))));

endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic [2:0]    bytes,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q <= CW'(bytes));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= last_o ? '0 : cnt_q - CW'(bytes);
        end
    end

    p_count_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bad_cfg,
    input  logic       len_zero,
    input  logic       gnt,
    input  logic       ack,
    input  logic       rel_ok,
    input  logic       cnt_last,
    output seq_state_t state_o,
    output logic       load_o,
    output logic       src_step_o,
    output logic       dst_step_o,
    output logic       done_o,
    output logic       err_o
);
    seq_state_t state_q, resume_q;
    logic       done_q, err_q;

    assign state_o    = state_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign load_o     = (state_q == ST_IDLE) && start && !bad_cfg && !len_zero;
    assign src_step_o = (state_q == ST_RD) && ack;
    assign dst_step_o = (state_q == ST_WR) && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            resume_q <= ST_RD;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (bad_cfg) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q  <= 1'b0;
                            done_q <= len_zero;
                            if (!len_zero) begin
                                state_q  <= ST_REQ;
                                resume_q <= ST_RD;
                            end
                        end
                    end
                end
                ST_REQ: if (gnt) state_q <= resume_q;
                ST_RD: begin
                    if (ack) begin
                        resume_q <= ST_WR;
                        state_q  <= rel_ok ? ST_REL : ST_WR;
                    end
                end
                ST_WR: begin
                    if (ack) begin
                        resume_q <= ST_RD;
                        if (cnt_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= rel_ok ? ST_REL : ST_RD;
                        end
                    end
                end
                ST_REL:  state_q <= ST_REQ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD && !ack) |=> (state_q == ST_RD));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (state_q == ST_IDLE));

    p_rel_back_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL) |=> (state_q == ST_REQ));

    p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_word,
    input  logic              start,
    input  logic [AW-1:0]     src_start,
    input  logic [AW-1:0]     dst_start,
    input  logic [CW-1:0]     len_start,
    input  logic              gnt,
    input  logic              rel_req,
    input  logic              cyc_ack,
    output logic [AW-1:0]     bus_addr,
    output logic [2:0]        bus_size,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              sreq,
    output logic              greq,
    output logic              done,
    output logic              cfg_err
);
    chan_ctrl_t    ctrl_q;
    seq_state_t    state;
    logic          busy, load, src_step, dst_step, cnt_last, rel_ok, req_on;
    logic [2:0]    xfer_bytes;
    logic [AW-1:0] src_addr, dst_addr;

    assign busy       = (state != ST_IDLE);
    assign xfer_bytes = size_bytes(ctrl_q.xfer_sz);
    assign rel_ok     = rel_req && ctrl_q.rel_en && !ctrl_q.use_snoop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_wr && !busy) begin
            ctrl_q <= chan_ctrl_t'(cfg_word);
        end
    end

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .bad_cfg    (port_mismatch(ctrl_q)),
        .len_zero   (len_start == '0),
        .gnt        (gnt),
        .ack        (cyc_ack),
        .rel_ok     (rel_ok),
        .cnt_last   (cnt_last),
        .state_o    (state),
        .load_o     (load),
        .src_step_o (src_step),
        .dst_step_o (dst_step),
        .done_o     (done),
        .err_o      (cfg_err)
    );

    dma_seq_addr #(.AW(AW)) u_src (
        .clk (clk), .rst (rst), .load (load), .load_val (src_start),
        .step (src_step), .mode (ctrl_q.src_step), .bytes (xfer_bytes),
        .addr_o (src_addr)
    );

    dma_seq_addr #(.AW(AW)) u_dst (
        .clk (clk), .rst (rst), .load (load), .load_val (dst_start),
        .step (dst_step), .mode (ctrl_q.dst_step), .bytes (xfer_bytes),
        .addr_o (dst_addr)
    );

    dma_seq_count #(.CW(CW)) u_cnt (
        .clk (clk), .rst (rst), .load (load), .load_val (len_start),
        .dec (dst_step), .bytes (xfer_bytes), .last_o (cnt_last)
    );

    assign rd_stb   = (state == ST_RD);
    assign wr_stb   = (state == ST_WR);
    assign req_on   = (state == ST_REQ) || rd_stb || wr_stb;
    assign sreq     = req_on && ctrl_q.use_snoop;
    assign greq     = req_on && !ctrl_q.use_snoop;
    assign bus_addr = rd_stb ? src_addr : (wr_stb ? dst_addr : '0);
    assign bus_size = (rd_stb || wr_stb) ? xfer_bytes : 3'd0;

    p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr) |=> (ctrl_q == $past(ctrl_q)));

    p_snoop_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && cyc_ack && rel_req && ctrl_q.use_snoop) |=> wr_stb);

    p_one_line_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> (sreq != greq));

endmodule

// File: tb/tb_dma_seq_top.sv
module tb_dma_seq_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [11:0]   cfg_word = '0;
    logic          start = 1'b0;
    logic [AW-1:0] src_start = '0, dst_start = '0;
    logic [CW-1:0] len_start = '0;
    logic          gnt = 1'b0, rel_req = 1'b0, cyc_ack = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [2:0]    bus_size;
    logic          rd_stb, wr_stb, sreq, greq, done, cfg_err;

    always #2 clk = ~clk;

    dma_seq_top #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word), .start(start),
        .src_start(src_start), .dst_start(dst_start), .len_start(len_start),
        .gnt(gnt), .rel_req(rel_req), .cyc_ack(cyc_ack), .bus_addr(bus_addr),
        .bus_size(bus_size), .rd_stb(rd_stb), .wr_stb(wr_stb), .sreq(sreq),
        .greq(greq), .done(done), .cfg_err(cfg_err)
    );

    int tests = 0;
    int fails = 0;

    // reference model: 0 idle, 1 requesting, 2 reading, 3 writing, 4 released
    logic [11:0]   m_ctrl = '0;
    int            m_phase = 0;
    int            m_next = 2;
    logic [AW-1:0] m_src = '0, m_dst = '0;
    int            m_cnt = 0;
    bit            m_done = 0, m_err = 0;
    logic [15:0]   lfsr = 16'hACE1;
    int            rel_seen = 0;

    function automatic int nbytes(input logic [1:0] c);
        if (c == 2'b11) return 1;
        if (c == 2'b10) return 2;
        return 4;
    endfunction

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] md, input int b);
        if (md[1]) return a;
        if (md[0]) return a - AW'(b);
        return a + AW'(b);
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit rq;
        rq = (m_phase >= 1 && m_phase <= 3);
        check("R4 rd_stb", AW'(rd_stb), AW'(m_phase == 2));
        check("R4 wr_stb", AW'(wr_stb), AW'(m_phase == 3));
        check("R3 bus_addr", bus_addr, (m_phase == 2) ? m_src : (m_phase == 3) ? m_dst : '0);
        check("R2 bus_size", AW'(bus_size), (m_phase == 2 || m_phase == 3) ? AW'(nbytes(m_ctrl[1:0])) : '0);
        check("R6 sreq", AW'(sreq), AW'(rq && m_ctrl[10]));
        check("R6 greq", AW'(greq), AW'(rq && !m_ctrl[10]));
        check("R5 done", AW'(done), AW'(m_done));
        check("R9 cfg_err", AW'(cfg_err), AW'(m_err));
    endtask

    task automatic model_step();
        int  b;
        bit  relx;
        b    = nbytes(m_ctrl[1:0]);
        relx = rel_req && m_ctrl[11] && !m_ctrl[10];
        if (m_phase == 0) begin
            if (start) begin
                if ((m_ctrl[8] || m_ctrl[9]) && nbytes(m_ctrl[3:2]) != b) begin
                    m_err = 1;
                end else begin
                    m_err  = 0;
                    m_done = (len_start == 0);
                    if (len_start != 0) begin
                        m_src = src_start; m_dst = dst_start; m_cnt = int'(len_start);
                        m_phase = 1; m_next = 2;
                    end
                end
            end
            if (cfg_wr) m_ctrl = cfg_word;
        end else if (m_phase == 1) begin
            if (gnt) m_phase = m_next;
        end else if (m_phase == 2) begin
            if (cyc_ack) begin
                m_src = stepped(m_src, m_ctrl[5:4], b);
                m_next = 3;
                m_phase = relx ? 4 : 3;
                if (relx) rel_seen++;
            end
        end else if (m_phase == 3) begin
            if (cyc_ack) begin
                m_dst = stepped(m_dst, m_ctrl[7:6], b);
                m_next = 2;
                if (m_cnt <= b) begin
                    m_cnt = 0; m_done = 1; m_phase = 0;
                end else begin
                    m_cnt -= b;
                    m_phase = relx ? 4 : 2;
                    if (relx) rel_seen++;
                end
            end
        end else begin
            m_phase = 1;
        end
    endtask

    task automatic cycle();
        compare();
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gnt     = (m_phase == 1) && lfsr[1];
        cyc_ack = (m_phase == 2 || m_phase == 3) && (lfsr[2] || lfsr[5]);
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [11:0] w);
        cfg_wr = 1'b1; cfg_word = w;
        cycle();
        cfg_wr = 1'b0;
    endtask

    task automatic kick(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
        start = 1'b1; src_start = s; dst_start = d; len_start = CW'(n);
        cycle();
        start = 1'b0;
    endtask

    task automatic run_out();
        for (int i = 0; i < 3000 && m_phase != 0; i++) cycle();
        cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 idle strobes", AW'({rd_stb, wr_stb}), '0);
        check("R1 idle requests", AW'({sreq, greq}), '0);
        check("R1 idle flags", AW'({done, cfg_err}), '0);
        check("R1 idle bus", bus_addr | AW'(bus_size), '0);
        cycle();

        // R4 R3: memory to memory, incrementing, 4-byte, general request
        write_cfg(12'h000);
        kick(32'h0000_1000, 32'h0000_2000, 12);
        check("R6 request after start", AW'(greq), 1);
        run_out();
        check("R5 done after run", AW'(done), 1);

        // R2 R3: 2-byte, source decrements, destination holds, snoop line
        write_cfg(12'b0100_1001_0010);
        kick(32'h0000_0100, 32'h0000_8000, 6);
        check("R6 snoop line chosen", AW'({sreq, greq}), 2);
        run_out();

        // R2 R3: 1-byte, source held, destination decrements, address wrap
        write_cfg(12'b0000_0110_0011);
        kick(32'h0000_0040, 32'h0000_0001, 3);
        run_out();

        // R5: count not a multiple of size (6 bytes at 4 per write)
        write_cfg(12'h001);
        kick(32'h0000_3000, 32'h0000_4000, 6);
        run_out();

        // R7: general line with release honoured
        rel_seen = 0;
        write_cfg(12'b1000_0000_0010);
        kick(32'h0000_5000, 32'h0000_6000, 20);
        for (int i = 0; i < 8; i++) cycle();
        rel_req = 1'b1;
        for (int i = 0; i < 12; i++) cycle();
        rel_req = 1'b0;
        run_out();
        check("R7 release occurred", AW'(rel_seen > 0), 1);

        // R8: release ignored in snoop mode and when disabled
        rel_seen = 0;
        rel_req = 1'b1;
        write_cfg(12'b1100_0000_0000);
        kick(32'h0000_7000, 32'h0000_7800, 16);
        run_out();
        write_cfg(12'b0000_0000_0000);
        kick(32'h0000_7100, 32'h0000_7900, 16);
        run_out();
        rel_req = 1'b0;
        check("R8 no release taken", AW'(rel_seen), 0);

        // R9: I/O source with port size 4 and transfer size 1 is refused
        write_cfg(12'b0001_0000_0011);
        kick(32'h0000_1111, 32'h0000_2222, 8);
        check("R9 error flagged", AW'(cfg_err), 1);
        check("R9 stays idle", AW'({sreq, greq, rd_stb}), 0);
        cycle();
        // R9: memory only, mismatched port size ignored
        write_cfg(12'b0000_0000_0011);
        kick(32'h0000_1111, 32'h0000_2222, 2);
        check("R9 error cleared", AW'(cfg_err), 0);
        run_out();
        // R9: I/O destination with matching port size accepted
        write_cfg(12'b0010_0000_1010);
        kick(32'h0000_0010, 32'h0000_0F00, 4);
        check("R9 matched io accepted", AW'(greq), 1);
        run_out();

        // R10: control write during a run is discarded
        write_cfg(12'b0000_0000_0010);
        kick(32'h0000_9000, 32'h0000_A000, 4);
        cfg_wr = 1'b1; cfg_word = 12'b0100_0000_0011;
        cycle();
        cfg_wr = 1'b0;
        run_out();
        kick(32'h0000_9100, 32'h0000_A100, 2);
        for (int i = 0; i < 200 && !rd_stb; i++) cycle();
        check("R10 old size kept", AW'(bus_size), 2);
        check("R10 old line kept", AW'(greq), 1);
        run_out();

        // R11: zero count finishes at once
        kick(32'h0, 32'h0, 0);
        check("R11 done without request", AW'({done, sreq, greq}), 4);
        cycle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule